// File: doc/BRIEF.md
# Key-Protected DAC Control Registers

This block sits between a simple synchronous register bus and a 10-bit digital-to-analog converter path. It keeps two live registers. A one-bit mode register chooses whether the converter takes its samples directly from the data register or from a separate waveform synthesizer. A 10-bit data register holds the code that drives the converter in direct mode. The block brings out the mode bit as a select line, the raw code, and the same code converted to straight binary for the converter.

Neither live register can be changed by a single bus write. Software must first write an opening key to one key address, then write the new value to the mode or data address, then write a closing key to a second key address. The value written between the keys waits in a shadow register, and only the closing key copies it into the live register that was addressed. A wrong key, a stray write, or a closing key with no staged value abandons the sequence, and the shadow is discarded. Reads can be made at any time and do not disturb a sequence that is in progress.

The data code is two's complement: 0x000 is mid-scale, 0x200 is the most negative level and 0x1FF is the most positive level.

Top module: `dac_keyed_regs`

## Requirements
- R1: After a synchronous active-low reset the mode bit is 0, the data code is 0x000, the straight-binary level is 0x200, and reads of the mode and data addresses return 0x0000.
- R2: The mode register sits at address 0x0. `dac_direct` shows the committed mode bit: 1 selects direct data, 0 selects the synthesized waveform. A committed write stores write-data bit 0. A read returns the bit in bit 0, and bits 15:1 read as zero.
- R3: The data register sits at address 0x1. A committed write stores write-data bits 9:0. `dac_code` shows them, a read returns them in bits 9:0, and bits 15:10 read as zero.
- R4: `dac_level` equals (`dac_code` + 512) mod 1024: 0x200 gives 0x000, 0x000 gives 0x200, and 0x1FF gives 0x3FF.
- R5: A protected write has three steps in this order. First 0x0007 is written to the opening-key address 0x2. Then the value is written to address 0x0 or 0x1. Then 0x00B9 is written to the closing-key address 0x3. A key matches only if all 16 write-data bits are equal to it. The live register takes the value on the clock edge that accepts the closing-key write.
- R6: The closing key commits only the register that was written after the opening key. The other live register keeps its value.
- R7: A value written between the keys is not visible on the outputs or on reads until the closing key has been accepted.
- R8: A write to address 0x0 or 0x1 that does not follow an accepted opening key leaves both live registers unchanged.
- R9: A wrong value written to either key address abandons the sequence. A later correct closing key then commits nothing.
- R10: A write between the steps to any other address abandons the sequence. This covers unmapped addresses and a second value write.
- R11: A closing key that arrives right after the opening key, with no value write in between, abandons the sequence. A following value write and closing key then change nothing.
- R12: `rd_data` is registered. It is loaded on a clock edge where `rd_en` is high and holds otherwise. Reads of the key addresses and of unmapped addresses return 0x0000. A read made between the steps does not break the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address, shared by reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| dac_direct | output | 1 | Committed mode: 1 direct data, 0 synthesized waveform |
| dac_code | output | 10 | Committed two's-complement DAC code |
| dac_level | output | 10 | The same code in straight binary |

## Verification
Every one of the 1024 codes is committed through a full protected sequence. The live code, the straight-binary level and the read-back value are each compared with arithmetic in the bench, which catches a bad bit or a wrong sign flip anywhere in the code range. A sweep of unprotected writes over many values and both register addresses shows that writes without the opening key change nothing. Each way of breaking the sequence is then tried, and each is followed by a correct closing key: a bad opening key, a bad closing key, a key with upper bits set, an unmapped write, a doubled value write, and a closing key before any value. This separates a design that really discards the shadow from one that only waits for the next good key. Reads placed between the steps, and mode commits that leave the data register alone, confirm that reads leave the sequence intact and that a commit reaches only the register it targets.

// File: rtl/dacreg_pkg.sv
// Shared types for the key-protected DAC register block.
// Assumes: nothing; pure type definitions.
package dacreg_pkg;

    // Progress through the open-key / value / close-key protocol
    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_OPEN   = 2'd1,
        KS_STAGED = 2'd2
    } key_state_e;

    // Which live register a staged value is aimed at
    typedef enum logic {
        TGT_MODE = 1'b0,
        TGT_DATA = 1'b1
    } target_e;

endpackage

// File: rtl/dacreg_key_seq.sv
// Key sequencer: tracks the open-key / value / close-key protocol, holds the
// staged value and its target, and pulses one commit strobe when the
// closing key completes a valid sequence.
// Assumes: one bus write per cycle at most; reads never reach this module.
module dacreg_key_seq
    import dacreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CODE_W = 10,
    parameter logic [ADDR_W-1:0] ADDR_MODE      = 4'h0,
    parameter logic [ADDR_W-1:0] ADDR_DATA      = 4'h1,
    parameter logic [ADDR_W-1:0] ADDR_KEY_OPEN  = 4'h2,
    parameter logic [ADDR_W-1:0] ADDR_KEY_CLOSE = 4'h3,
    parameter logic [DATA_W-1:0] KEY_OPEN_VAL   = 16'h0007,
    parameter logic [DATA_W-1:0] KEY_CLOSE_VAL  = 16'h00B9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit_mode,
    output logic              commit_data,
    output logic [CODE_W-1:0] staged_value
);

    key_state_e        state, state_nxt;
    target_e           staged_tgt;
    logic              hit_mode, hit_data, hit_open, hit_close, hit_value;
    logic              open_ok, close_ok, capture, commit;

    // Address and key decode for the current write
    always_comb begin
        hit_mode  = (wr_addr == ADDR_MODE);
        hit_data  = (wr_addr == ADDR_DATA);
        hit_open  = (wr_addr == ADDR_KEY_OPEN);
        hit_close = (wr_addr == ADDR_KEY_CLOSE);
        hit_value = hit_mode || hit_data;
        open_ok   = (wr_data == KEY_OPEN_VAL);
        close_ok  = (wr_data == KEY_CLOSE_VAL);
    end

    // Next protocol state; any write that does not advance the sequence aborts it
    always_comb begin
        state_nxt = state;
        if (wr_en) begin
            if (hit_open)
                state_nxt = open_ok ? KS_OPEN : KS_IDLE;
            else if (hit_value)
                state_nxt = (state == KS_OPEN) ? KS_STAGED : KS_IDLE;
            else
                state_nxt = KS_IDLE;
        end
    end

    // Capture and commit strobes derived from state and the current write
    always_comb begin
        capture = wr_en && hit_value && (state == KS_OPEN);
        commit  = wr_en && hit_close && close_ok && (state == KS_STAGED);
    end

    // Protocol state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= state_nxt;
    end

    // Shadow register: value and target staged between the two keys
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_value <= '0;
            staged_tgt   <= TGT_MODE;
        end else if (capture) begin
            staged_value <= hit_mode ? CODE_W'(wr_data[0]) : wr_data[CODE_W-1:0];
            staged_tgt   <= hit_mode ? TGT_MODE : TGT_DATA;
        end
    end

    // Route the commit to the one register that was staged
    always_comb begin
        commit_mode = commit && (staged_tgt == TGT_MODE);
        commit_data = commit && (staged_tgt == TGT_DATA);
    end

    // R5
    // staged_entry_chk: a staged value only follows an accepted opening key
    staged_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_STAGED && $past(state) != KS_STAGED) |-> $past(state) == KS_OPEN);

    // R10
    // stray_write_chk: a write to an unmapped address always abandons the sequence
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_value && !hit_open && !hit_close) |=> state == KS_IDLE);

    // R11
    // early_close_chk: a closing key straight after the opening key returns to idle
    early_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_close && state == KS_OPEN) |=> state == KS_IDLE);

    // R6
    // single_commit_chk: at most one live register is committed per cycle
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_mode, commit_data}));

endmodule

// File: rtl/dacreg_live_bank.sv
// Live register bank: holds the committed mode bit and DAC code and
// produces the straight-binary level for the converter.
// Assumes: commit strobes are mutually exclusive single-cycle pulses.
module dacreg_live_bank #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_mode,
    input  logic              commit_data,
    input  logic [CODE_W-1:0] staged_value,
    output logic              mode_q,
    output logic [CODE_W-1:0] code_q,
    output logic [CODE_W-1:0] level
);

    localparam logic [CODE_W-1:0] SIGN_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

    // Mode register: loads bit 0 of the shadow on a mode commit
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= 1'b0;
        else if (commit_mode) mode_q <= staged_value[0];
    end

    // Data register: loads the full shadow code on a data commit
    always_ff @(posedge clk) begin
        if (!rst_n)           code_q <= '0;
        else if (commit_data) code_q <= staged_value;
    end

    // Two's complement to straight binary: invert the sign bit
    always_comb level = code_q ^ SIGN_FLIP;

    // R6
    // mode_hold_chk: a data commit never disturbs the mode bit
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_data |=> $stable(mode_q));

endmodule

// File: rtl/dacreg_read_port.sv
// Read port: registers the read data selected by address; reserved bits and
// the key and unmapped addresses read as zero.
// Assumes: reads have no side effects anywhere in the block.
module dacreg_read_port #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CODE_W = 10,
    parameter logic [ADDR_W-1:0] ADDR_MODE      = 4'h0,
    parameter logic [ADDR_W-1:0] ADDR_DATA      = 4'h1,
    parameter logic [ADDR_W-1:0] ADDR_KEY_OPEN  = 4'h2,
    parameter logic [ADDR_W-1:0] ADDR_KEY_CLOSE = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              mode_q,
    input  logic [CODE_W-1:0] code_q,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_sel;

    // Select the zero-extended live value for the addressed register
    always_comb begin
        if (rd_addr == ADDR_MODE)      rd_sel = DATA_W'(mode_q);
        else if (rd_addr == ADDR_DATA) rd_sel = DATA_W'(code_q);
        else                           rd_sel = '0;
    end

    // Read data register: loads only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_sel;
    end

    // R12
    // key_read_zero_chk: key addresses read back as zero
    key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == ADDR_KEY_OPEN || rd_addr == ADDR_KEY_CLOSE)) |=> rd_data == '0);

    // R12
    // read_hold_chk: read data holds when no read is made
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/dac_keyed_regs.sv
// Top of the key-protected DAC register block: mode and data registers
// that change only through the open-key / value / close-key sequence.
// Assumes: single-cycle bus strobes; bus_addr is shared by reads and writes.
module dac_keyed_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CODE_W = 10,
    parameter logic [ADDR_W-1:0] ADDR_MODE      = 4'h0,
    parameter logic [ADDR_W-1:0] ADDR_DATA      = 4'h1,
    parameter logic [ADDR_W-1:0] ADDR_KEY_OPEN  = 4'h2,
    parameter logic [ADDR_W-1:0] ADDR_KEY_CLOSE = 4'h3,
    parameter logic [DATA_W-1:0] KEY_OPEN_VAL   = 16'h0007,
    parameter logic [DATA_W-1:0] KEY_CLOSE_VAL  = 16'h00B9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              dac_direct,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] dac_level
);

    logic              commit_mode, commit_data;
    logic [CODE_W-1:0] staged_value;

    dacreg_key_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
        .ADDR_MODE(ADDR_MODE), .ADDR_DATA(ADDR_DATA),
        .ADDR_KEY_OPEN(ADDR_KEY_OPEN), .ADDR_KEY_CLOSE(ADDR_KEY_CLOSE),
        .KEY_OPEN_VAL(KEY_OPEN_VAL), .KEY_CLOSE_VAL(KEY_CLOSE_VAL)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(bus_addr), .wr_data(wr_data),
        .commit_mode(commit_mode), .commit_data(commit_data),
        .staged_value(staged_value)
    );

    dacreg_live_bank #(.CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .commit_mode(commit_mode), .commit_data(commit_data),
        .staged_value(staged_value),
        .mode_q(dac_direct), .code_q(dac_code), .level(dac_level)
    );

    dacreg_read_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
        .ADDR_MODE(ADDR_MODE), .ADDR_DATA(ADDR_DATA),
        .ADDR_KEY_OPEN(ADDR_KEY_OPEN), .ADDR_KEY_CLOSE(ADDR_KEY_CLOSE)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(bus_addr),
        .mode_q(dac_direct), .code_q(dac_code),
        .rd_data(rd_data)
    );

    // R5
    // code_commit_chk: the live code changes only after a correct closing-key write
    code_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dac_code != $past(dac_code)) |->
        $past(wr_en && bus_addr == ADDR_KEY_CLOSE && wr_data == KEY_CLOSE_VAL));

    // R8
    // mode_commit_chk: the mode bit changes only after a correct closing-key write
    mode_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dac_direct != $past(dac_direct)) |->
        $past(wr_en && bus_addr == ADDR_KEY_CLOSE && wr_data == KEY_CLOSE_VAL));

endmodule

// File: tb/tb_dac_keyed_regs.sv
// Self-checking bench for dac_keyed_regs: sweeps every code through the key
// protocol and exercises each way of breaking the sequence.
module tb_dac_keyed_regs;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_MODE  = 4'h0;
    localparam logic [3:0] A_DATA  = 4'h1;
    localparam logic [3:0] A_OPEN  = 4'h2;
    localparam logic [3:0] A_CLOSE = 4'h3;
    localparam logic [15:0] K_OPEN  = 16'h0007;
    localparam logic [15:0] K_CLOSE = 16'h00B9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        dac_direct;
    logic [9:0]  dac_code;
    logic [9:0]  dac_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic        exp_mode = 1'b0;
    logic [9:0]  exp_code = '0;
    logic [15:0] rv;

    dac_keyed_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .dac_direct(dac_direct), .dac_code(dac_code), .dac_level(dac_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check_live(input string req);
        chk(req, {15'd0, dac_direct}, {15'd0, exp_mode});
        chk(req, {6'd0, dac_code}, {6'd0, exp_code});
        chk(req, {6'd0, dac_level}, 16'((int'(exp_code) + 512) % 1024));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run is counted as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_live("R1");
        rd(A_MODE, rv); chk("R1 mode read", rv, 16'h0000);
        rd(A_DATA, rv); chk("R1 data read", rv, 16'h0000);

        // R3 R4 R5: every code through a full protected sequence
        for (int c = 0; c < 1024; c++) begin
            wr(A_OPEN, K_OPEN);
            wr(A_DATA, 16'hFC00 | 16'(c));
            wr(A_CLOSE, K_CLOSE);
            exp_code = 10'(c);
            check_live("R4 R5 sweep");
            rd(A_DATA, rv); chk("R3 read back", rv, 16'(c));
        end

        // R4 named corners
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0200); wr(A_CLOSE, K_CLOSE);
        chk("R4 most negative", {6'd0, dac_level}, 16'h0000);
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h01FF); wr(A_CLOSE, K_CLOSE);
        chk("R4 most positive", {6'd0, dac_level}, 16'h03FF);
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0000); wr(A_CLOSE, K_CLOSE);
        chk("R4 midscale", {6'd0, dac_level}, 16'h0200);
        exp_code = 10'h000;

        // R2 R6: mode commits leave the data register alone
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0155); wr(A_CLOSE, K_CLOSE);
        exp_code = 10'h155;
        wr(A_OPEN, K_OPEN); wr(A_MODE, 16'hFFFF); wr(A_CLOSE, K_CLOSE);
        exp_mode = 1'b1;
        check_live("R2 R6 mode set");
        rd(A_MODE, rv); chk("R2 mode read", rv, 16'h0001);
        wr(A_OPEN, K_OPEN); wr(A_MODE, 16'hFFFE); wr(A_CLOSE, K_CLOSE);
        exp_mode = 1'b0;
        check_live("R2 R6 mode clear");
        wr(A_OPEN, K_OPEN); wr(A_MODE, 16'h0001); wr(A_CLOSE, K_CLOSE);
        exp_mode = 1'b1;
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h02AA); wr(A_CLOSE, K_CLOSE);
        exp_code = 10'h2AA;
        check_live("R6 data commit keeps mode");

        // R7: staged value hidden until the closing key
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0033);
        check_live("R7 before close");
        rd(A_DATA, rv); chk("R7 read before close", rv, 16'h02AA);
        wr(A_CLOSE, K_CLOSE);
        exp_code = 10'h033;
        check_live("R7 after close");

        // R8: unprotected writes are ignored
        for (int v = 0; v < 64; v++) begin
            wr(A_DATA, 16'(v * 1021));
            wr(A_MODE, 16'(v));
        end
        wr(A_CLOSE, K_CLOSE);
        check_live("R8 unprotected");

        // R9: wrong keys abandon the sequence
        wr(A_OPEN, 16'h0006); wr(A_DATA, 16'h0111); wr(A_CLOSE, K_CLOSE);
        check_live("R9 bad open");
        wr(A_OPEN, 16'h0107); wr(A_DATA, 16'h0111); wr(A_CLOSE, K_CLOSE);
        check_live("R9 open upper bits");
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0111); wr(A_CLOSE, 16'h00B8);
        wr(A_CLOSE, K_CLOSE);
        check_live("R9 bad close");
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0111); wr(A_OPEN, 16'h0000);
        wr(A_CLOSE, K_CLOSE);
        check_live("R9 bad open mid-sequence");

        // R10: stray writes abandon the sequence
        wr(A_OPEN, K_OPEN); wr(4'h5, 16'h0000); wr(A_DATA, 16'h0122); wr(A_CLOSE, K_CLOSE);
        check_live("R10 stray before value");
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0122); wr(4'hF, 16'h0000); wr(A_CLOSE, K_CLOSE);
        check_live("R10 stray after value");
        wr(A_OPEN, K_OPEN); wr(A_DATA, 16'h0122); wr(A_DATA, 16'h0123); wr(A_CLOSE, K_CLOSE);
        check_live("R10 double value");
        wr(A_OPEN, K_OPEN); wr(A_MODE, 16'h0000); wr(A_DATA, 16'h0124); wr(A_CLOSE, K_CLOSE);
        check_live("R10 mode then data");

        // R11: closing key with no staged value
        wr(A_OPEN, K_OPEN); wr(A_CLOSE, K_CLOSE); wr(A_DATA, 16'h0144); wr(A_CLOSE, K_CLOSE);
        check_live("R11 early close");

        // R12: reads between steps keep the sequence; key reads are zero
        rd(A_OPEN, rv);  chk("R12 open key read", rv, 16'h0000);
        rd(A_CLOSE, rv); chk("R12 close key read", rv, 16'h0000);
        rd(4'h9, rv);    chk("R12 unmapped read", rv, 16'h0000);
        wr(A_OPEN, K_OPEN);
        rd(A_DATA, rv);
        wr(A_DATA, 16'h03C3);
        rd(A_MODE, rv); chk("R12 mid-sequence read", rv, 16'h0001);
        wr(A_CLOSE, K_CLOSE);
        exp_code = 10'h3C3;
        check_live("R12 sequence survives reads");
        @(negedge clk);
        chk("R12 read data holds", rv, rd_data);

        finish_run();
    end

endmodule